// File: doc/BRIEF.md
# Microwire EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial EEPROM of the Microwire kind. It drives the memory's chip select, serial clock and serial data input, and samples the memory's serial data output. A caller puts a word address and an address-length choice on the request pins, pulses `req_valid` while the block is idle, and then waits for `done`. The read word appears on `rd_data`.

For each request the block raises chip select and waits one half-period. It then clocks out the read opcode and the address, most significant bit first. Next it clocks in sixteen data bits, most significant bit first, and drops chip select. After a further half-period of chip-select low it pulses `done`. The length of every half-period is set by `half_div`, and the value is captured when the request is accepted. The address length is selectable per request, so one controller serves both small EEPROMs (6-bit addresses) and larger ones (8-bit addresses).

Top module: `mwr_reader`

## Requirements
- R1: While reset is asserted, and directly after it, `mw_cs`, `mw_clk`, `mw_mosi`, `busy` and `done` are all low.
- R2: A `req_valid` seen while `busy` is low is accepted, and `busy` is high on the next cycle. `busy` stays high until the cycle in which `done` is high. In that cycle `busy` is low. `done` is high for exactly one cycle.
- R3: A `req_valid` seen while `busy` is high is ignored. It produces no serial traffic and no `done`.
- R4: `mw_cs` rises while `mw_clk` is low. It is high for exactly two half-periods before the first rising edge of `mw_clk`: one half-period of setup, then the low half of the first bit. `mw_clk` is high only while `mw_cs` is high.
- R5: The command bits, in order, are 1, 1, 0, followed by the address, most significant bit first. With `req_wide`=1 the address is `req_addr[7:0]` (11 command bits). With `req_wide`=0 it is `req_addr[5:0]` (9 command bits), and `req_addr[7:6]` are ignored.
- R6: `mw_mosi` changes only while `mw_clk` is low. It is stable for the whole high half of every serial clock.
- R7: Sixteen data bits are taken from `mw_miso` at the end of each high half, most significant bit first. `rd_data` holds the word when `done` pulses and keeps it until the next transaction.
- R8: `mw_mosi` is low at every rising edge of `mw_clk` during the data phase.
- R9: Each high half of `mw_clk` lasts `half_div`+1 clock cycles. The `half_div` value used is the one present when the request was accepted.
- R10: Between two transactions, `mw_cs` stays low for at least `half_div`+1 clock cycles.
- R11: A transaction has exactly (command length + 16) rising edges of `mw_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request; taken only while idle |
| req_addr | input | 8 | Word address (low 6 bits used in narrow mode) |
| req_wide | input | 1 | 1 selects an 8-bit address, 0 selects a 6-bit address |
| half_div | input | 8 | Serial half-period length minus one, in clock cycles |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse when `rd_data` is valid |
| rd_data | output | 16 | Word read from the EEPROM |
| mw_cs | output | 1 | EEPROM chip select |
| mw_clk | output | 1 | EEPROM serial clock |
| mw_mosi | output | 1 | Serial data to the EEPROM |
| mw_miso | input | 1 | Serial data from the EEPROM |

## Verification
The embedded assertions check a set of properties on every cycle:
- the serial clock is never high outside chip select;
- chip select always rises with the clock low;
- data-out holds through each high half;
- the serial clock toggles only on a divider tick;
- the busy and done handshake keeps its shape.

Other properties can only be shown by the bench's scenarios, using an EEPROM model and a scoreboard:
- the exact opcode and address bits, for both address lengths and with the ignored upper address bits set;
- the word assembled from the data phase;
- the exact half-period length for several divider values;
- the setup time before the first clock;
- the chip-select gap between back-to-back requests;
- that a request issued mid-transaction is ignored.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
   localparam logic [2:0] MWR_RD_OP = 3'b110;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_CMD,
      ST_DATA,
      ST_GAP
   } mwr_state_e;
endpackage

// File: rtl/mwr_halftick.sv
module mwr_halftick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] lim,
   output logic             tick
);
   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("mwr_halftick: DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == lim);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || tick) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
   end

   // R9
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $past(tick)) |-> (cnt == '0));
endmodule

// File: rtl/mwr_cmdform.sv
module mwr_cmdform #(
   parameter int NARROW_AW = 6,
   parameter int WIDE_AW   = 8,
   parameter int CNT_W     = 4,
   localparam int CMD_W    = 3 + WIDE_AW
) (
   input  logic [WIDE_AW-1:0] addr,
   input  logic               wide,
   output logic [CMD_W-1:0]   cmd,
   output logic [CNT_W-1:0]   last_idx
);
   import mwr_pkg::*;

   generate
      if (NARROW_AW < 1 || NARROW_AW > WIDE_AW) begin : g_bad_aw
         $error("mwr_cmdform: need 1 <= NARROW_AW <= WIDE_AW");
      end
   endgenerate

   logic [CMD_W-1:0] narrow_cmd;

   generate
      if (WIDE_AW > NARROW_AW) begin : g_pad
         assign narrow_cmd = {MWR_RD_OP, addr[NARROW_AW-1:0],
                              {(WIDE_AW-NARROW_AW){1'b0}}};
      end else begin : g_nopad
         assign narrow_cmd = {MWR_RD_OP, addr[NARROW_AW-1:0]};
      end
   endgenerate

   assign cmd      = wide ? {MWR_RD_OP, addr} : narrow_cmd;
   assign last_idx = wide ? CNT_W'(CMD_W - 1) : CNT_W'(3 + NARROW_AW - 1);
endmodule

// File: rtl/mwr_reader.sv
module mwr_reader #(
   parameter int NARROW_AW = 6,
   parameter int WIDE_AW   = 8,
   parameter int DATA_W    = 16,
   parameter int DIV_W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [WIDE_AW-1:0] req_addr,
   input  logic               req_wide,
   input  logic [DIV_W-1:0]   half_div,
   output logic               busy,
   output logic               done,
   output logic [DATA_W-1:0]  rd_data,
   output logic               mw_cs,
   output logic               mw_clk,
   output logic               mw_mosi,
   input  logic               mw_miso
);
   import mwr_pkg::*;

   localparam int CMD_W = 3 + WIDE_AW;
   localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
   localparam int CNT_W = $clog2(MAXB);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("mwr_reader: DATA_W must be at least 2");
      end
   endgenerate

   mwr_state_e       state;
   logic [CMD_W-1:0] cmd_w, cmd_sr;
   logic [CNT_W-1:0] last_w, bit_cnt;
   logic [DIV_W-1:0] lim_r;
   logic [DATA_W-1:0] data_sr;
   logic             sk_r, done_r, tick, run;

   assign run = (state != ST_IDLE);

   mwr_cmdform #(
      .NARROW_AW(NARROW_AW),
      .WIDE_AW  (WIDE_AW),
      .CNT_W    (CNT_W)
   ) u_cmd (
      .addr    (req_addr),
      .wide    (req_wide),
      .cmd     (cmd_w),
      .last_idx(last_w)
   );

   mwr_halftick #(.DIV_W(DIV_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .lim  (lim_r),
      .tick (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cmd_sr  <= '0;
         bit_cnt <= '0;
         lim_r   <= '0;
         data_sr <= '0;
         sk_r    <= 1'b0;
         done_r  <= 1'b0;
      end else begin
         done_r <= 1'b0;
         case (state)
            ST_IDLE: if (req_valid) begin
               state   <= ST_SETUP;
               cmd_sr  <= cmd_w;
               bit_cnt <= last_w;
               lim_r   <= half_div;
            end
            ST_SETUP: if (tick) state <= ST_CMD;
            ST_CMD: if (tick) begin
               if (!sk_r) sk_r <= 1'b1;
               else begin
                  sk_r <= 1'b0;
                  if (bit_cnt == '0) begin
                     state   <= ST_DATA;
                     bit_cnt <= CNT_W'(DATA_W - 1);
                  end else begin
                     bit_cnt <= bit_cnt - 1'b1;
                     cmd_sr  <= {cmd_sr[CMD_W-2:0], 1'b0};
                  end
               end
            end
            ST_DATA: if (tick) begin
               if (!sk_r) sk_r <= 1'b1;
               else begin
                  sk_r    <= 1'b0;
                  data_sr <= {data_sr[DATA_W-2:0], mw_miso};
                  if (bit_cnt == '0) state <= ST_GAP;
                  else               bit_cnt <= bit_cnt - 1'b1;
               end
            end
            ST_GAP: if (tick) begin
               state  <= ST_IDLE;
               done_r <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = run;
   assign done    = done_r;
   assign rd_data = data_sr;
   assign mw_cs   = (state == ST_SETUP) || (state == ST_CMD) || (state == ST_DATA);
   assign mw_clk  = sk_r;
   assign mw_mosi = (state == ST_CMD) && cmd_sr[CMD_W-1];

   // R4
   clk_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mw_clk |-> mw_cs);
   // R4
   cs_rise_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mw_cs) |-> !mw_clk);
   // R6
   mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_clk && $past(mw_clk)) |-> $stable(mw_mosi));
   // R2
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R2
   busy_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   // R2
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   clk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_clk != $past(mw_clk)) |-> $past(tick));
endmodule

// File: tb/mwr_reader_test.sv
module mwr_reader_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_addr = '0;
   logic        req_wide = 1'b0;
   logic [7:0]  half_div = '0;
   logic        busy, done, mw_cs, mw_clk, mw_mosi;
   logic        mw_miso = 1'b1;
   logic [15:0] rd_data;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   mwr_reader uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_wide(req_wide), .half_div(half_div), .busy(busy), .done(done),
      .rd_data(rd_data), .mw_cs(mw_cs), .mw_clk(mw_clk), .mw_mosi(mw_mosi),
      .mw_miso(mw_miso)
   );

   task automatic chk(input string req, input logic ok,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] memf(input logic [7:0] a);
      return {a, ~a} ^ 16'hC35A;
   endfunction

   // expectations of the current transaction
   logic [15:0] exp_q[$];
   int          m_len = 11;
   int          m_lim = 0;
   logic [15:0] m_cmd = '0;
   logic        started = 1'b0;
   logic [15:0] last_data = '0;

   // EEPROM model
   int          rise_n = 0, fall_n = 0;
   logic [15:0] cmd_got = '0, word = '0;
   logic        mosi_data_bad = 1'b0;

   always @(posedge mw_cs) begin
      rise_n = 0; fall_n = 0; cmd_got = '0; mosi_data_bad = 1'b0;
   end

   always @(posedge mw_clk) if (mw_cs) begin
      rise_n++;
      if (rise_n <= m_len) cmd_got = {cmd_got[14:0], mw_mosi};
      else if (mw_mosi) mosi_data_bad = 1'b1;
      if (rise_n == m_len)
         word = memf((m_len == 11) ? cmd_got[7:0] : {2'b00, cmd_got[5:0]});
   end

   always @(negedge mw_clk) if (mw_cs) begin
      fall_n++;
      if (fall_n >= m_len && fall_n - m_len <= 15)
         mw_miso = word[15 - (fall_n - m_len)];
   end

   // cycle monitor
   int   hi_run = 0, pre_n = 0, low_n = 0, gap_lim = 0;
   logic prev_clk = 1'b0, prev_mosi = 1'b0, hold_bad = 1'b0, had_txn = 1'b0;
   logic prev_cs = 1'b0;

   always @(negedge clk) if (rst_n && started) begin
      if (mw_clk) hi_run++;
      else if (hi_run > 0) begin
         // R9: high half length
         chk("R9 high half length", hi_run == m_lim + 1, hi_run, m_lim + 1);
         hi_run = 0;
      end
      if (mw_clk && prev_clk && mw_mosi != prev_mosi) hold_bad = 1'b1;
      if (mw_cs && !prev_cs) begin
         if (had_txn)
            // R10: chip select gap between transactions
            chk("R10 cs low gap", low_n >= gap_lim + 1, low_n, gap_lim + 1);
         pre_n = 0;
         hold_bad = 1'b0;
      end
      if (mw_cs && !mw_clk && rise_n == 0) pre_n++;
      if (!mw_cs) low_n++;
      if (!mw_cs && prev_cs) begin
         // R4: setup before first clock
         chk("R4 cs setup cycles", pre_n == 2 * (m_lim + 1), pre_n, 2 * (m_lim + 1));
         // R11: clock count
         chk("R11 rising edge count", rise_n == m_len + 16, rise_n, m_len + 16);
         // R5: command bits
         chk("R5 command bits", cmd_got == m_cmd, cmd_got, m_cmd);
         // R8: mosi low in data phase
         chk("R8 mosi low in data", !mosi_data_bad, mosi_data_bad, 0);
         // R6: mosi stable in high half
         chk("R6 mosi stable while clk high", !hold_bad, hold_bad, 0);
         gap_lim = m_lim;
         low_n = 1;
         had_txn = 1'b1;
      end
      prev_clk = mw_clk; prev_mosi = mw_mosi; prev_cs = mw_cs;
   end

   // scoreboard monitor
   always @(negedge clk) if (rst_n && done) begin
      if (exp_q.size() == 0) begin
         chk("R3 unexpected done", 1'b0, rd_data, 0);
      end else begin
         logic [15:0] e;
         e = exp_q.pop_front();
         // R7: read data
         chk("R7 read word", rd_data == e, rd_data, e);
         last_data = e;
      end
   end

   task automatic do_read(input logic [7:0] a, input logic w, input logic [7:0] d);
      @(negedge clk);
      while (busy) @(negedge clk);
      req_addr = a; req_wide = w; half_div = d; req_valid = 1'b1;
      started = 1'b1;
      m_lim = d;
      m_len = w ? 11 : 9;
      m_cmd = w ? {5'b0, 3'b110, a} : {7'b0, 3'b110, a[5:0]};
      exp_q.push_back(memf(w ? a : {2'b00, a[5:0]}));
      @(negedge clk);
      req_valid = 1'b0;
      half_div = 8'hFF;
      // R2: busy after accept
      chk("R2 busy after accept", busy == 1'b1, busy, 1);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy || exp_q.size() != 0) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset outputs", {mw_cs, mw_clk, mw_mosi, busy, done} == 5'b0,
          {mw_cs, mw_clk, mw_mosi, busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 outputs after reset", {mw_cs, mw_clk, mw_mosi, busy, done} == 5'b0,
          {mw_cs, mw_clk, mw_mosi, busy, done}, 0);

      do_read(8'hA5, 1'b1, 8'd0);  wait_idle();
      do_read(8'h00, 1'b1, 8'd1);  wait_idle();
      do_read(8'hFF, 1'b1, 8'd3);  wait_idle();
      do_read(8'hD5, 1'b0, 8'd0);  wait_idle();   // R5 upper bits ignored
      do_read(8'h3F, 1'b0, 8'd2);  wait_idle();

      // R3: request during busy is ignored
      do_read(8'h5C, 1'b1, 8'd1);
      repeat (10) @(negedge clk);
      req_addr = 8'h33; req_wide = 1'b0; half_div = 8'd0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_idle();
      repeat (40) @(negedge clk);
      chk("R3 no second transaction", busy == 1'b0 && exp_q.size() == 0, busy, 0);
      // R7: data held after done
      chk("R7 rd_data held", rd_data == last_data, rd_data, last_data);

      // back to back, R10
      do_read(8'h81, 1'b1, 8'd0);
      do_read(8'h2A, 1'b0, 8'd0);
      wait_idle();
      repeat (5) @(negedge clk);
      chk("R2 idle at end", busy == 1'b0 && done == 1'b0, busy, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule